// File: doc/BRIEF.md
# Header Field Range Classifier

This block assigns a packet to a flow by comparing its header tuple against a small table of rules. The tuple has six fields: source address (32 bits), destination address (32 bits), source port (16 bits), destination port (16 bits), type-of-service byte and protocol byte. Each rule holds an enable bit, a low bound and a high bound for every field, and a flow number. A rule hits only when all six fields lie inside their inclusive bounds.

Every rule is compared in parallel on each lookup. When several enabled rules hit, the one with the lowest index supplies the flow. The result is registered, so it appears one clock after the header is presented. A miss reports flow 0 with the match flag low. Rules are loaded through a write port that replaces one whole rule per cycle.

Top module: `hdr_classifier`

## Requirements
- R1: After reset, res_valid, res_match and res_flow are 0 and every rule is disabled, so any lookup misses until rules are written.
- R2: A header presented with hdr_valid high at clock edge k gives res_valid high after edge k; with hdr_valid low, res_valid is low after that edge.
- R3: Bounds are packed into wr_lo and wr_hi as src address [111:80], dst address [79:48], src port [47:32], dst port [31:16], type-of-service [15:8], protocol [7:0]; a field equal to its low or its high bound is inside the range.
- R4: A field one below its low bound or one above its high bound stops that rule from hitting, whatever the other fields are.
- R5: When several enabled rules hit, res_flow is the flow of the hit with the lowest index.
- R6: A rule written with wr_rule_on low never hits, even if its ranges cover the header.
- R7: When no enabled rule hits a valid header, res_match is 0 and res_flow is 0.
- R8: A rule written at edge k is used by lookups sampled at later edges; a lookup sampled at edge k itself uses the previous table contents.
- R9: While res_valid is low, res_match and res_flow are 0.
- R10: Writing to an index already in use replaces all of its bounds and its flow; the old contents no longer hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_valid | input | 1 | Header tuple is valid this cycle |
| hdr_src_addr | input | 32 | Source address |
| hdr_dst_addr | input | 32 | Destination address |
| hdr_src_port | input | 16 | Source port |
| hdr_dst_port | input | 16 | Destination port |
| hdr_tos | input | 8 | Type-of-service byte |
| hdr_proto | input | 8 | Protocol byte |
| wr_en | input | 1 | Write one rule this cycle |
| wr_idx | input | 3 | Index of the rule to write |
| wr_rule_on | input | 1 | Enable bit of the written rule |
| wr_lo | input | 112 | Packed low bounds of the written rule |
| wr_hi | input | 112 | Packed high bounds of the written rule |
| wr_flow | input | 4 | Flow number of the written rule |
| res_valid | output | 1 | Result is valid |
| res_match | output | 1 | An enabled rule hit |
| res_flow | output | 4 | Flow of the winning rule, 0 on a miss |

## Verification
The hardest case to reach is a write and a lookup landing on the same clock edge, where the lookup must still see the old rule while the next one sees the new one. The bench drives both in one cycle against a header that only the rewritten rule can cover, then repeats the lookup a cycle later. Bound edges are probed one value inside and one outside each range so that an off-by-one comparator shows up as a wrong hit or a missed one, and overlapping rules are set up so that only the priority order decides the flow.

// File: rtl/hfc_pkg.sv
package hfc_pkg;

    typedef struct packed {
        logic [31:0] src_addr;
        logic [31:0] dst_addr;
        logic [15:0] src_port;
        logic [15:0] dst_port;
        logic [7:0]  tos;
        logic [7:0]  proto;
    } hdr_t;

    localparam int HDR_W = $bits(hdr_t);

    // Inclusive range test on every field of the tuple.
    function automatic logic tuple_in_range(input hdr_t h, input hdr_t lo, input hdr_t hi);
        logic ok;
        ok = (h.src_addr >= lo.src_addr) && (h.src_addr <= hi.src_addr);
        ok = ok && (h.dst_addr >= lo.dst_addr) && (h.dst_addr <= hi.dst_addr);
        ok = ok && (h.src_port >= lo.src_port) && (h.src_port <= hi.src_port);
        ok = ok && (h.dst_port >= lo.dst_port) && (h.dst_port <= hi.dst_port);
        ok = ok && (h.tos >= lo.tos) && (h.tos <= hi.tos);
        ok = ok && (h.proto >= lo.proto) && (h.proto <= hi.proto);
        return ok;
    endfunction

endpackage

// File: rtl/hfc_rule_table.sv
module hfc_rule_table
    import hfc_pkg::*;
#(
    parameter int NUM_RULES = 8,
    parameter int FLOW_W    = 4,
    localparam int IDX_W    = $clog2(NUM_RULES)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_en,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic                             wr_on,
    input  hdr_t                             wr_lo,
    input  hdr_t                             wr_hi,
    input  logic [FLOW_W-1:0]                wr_flow,
    output logic [NUM_RULES-1:0]             rule_on,
    output hdr_t [NUM_RULES-1:0]             rule_lo,
    output hdr_t [NUM_RULES-1:0]             rule_hi,
    output logic [NUM_RULES-1:0][FLOW_W-1:0] rule_flow
);

    for (genvar i = 0; i < NUM_RULES; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                rule_on[i]   <= 1'b0;
                rule_lo[i]   <= '0;
                rule_hi[i]   <= '0;
                rule_flow[i] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                rule_on[i]   <= wr_on;
                rule_lo[i]   <= wr_lo;
                rule_hi[i]   <= wr_hi;
                rule_flow[i] <= wr_flow;
            end
        end
    end

endmodule

// File: rtl/hfc_rule_match.sv
module hfc_rule_match
    import hfc_pkg::*;
(
    input  hdr_t hdr,
    input  logic on,
    input  hdr_t lo,
    input  hdr_t hi,
    output logic hit
);

    always_comb hit = on && tuple_in_range(hdr, lo, hi);

endmodule

// File: rtl/hfc_prio_pick.sv
module hfc_prio_pick #(
    parameter int NUM_RULES = 8,
    parameter int FLOW_W    = 4
) (
    input  logic [NUM_RULES-1:0]             hits,
    input  logic [NUM_RULES-1:0][FLOW_W-1:0] flows,
    output logic                             any_hit,
    output logic [FLOW_W-1:0]                win_flow
);

    // Scan from the top index down so the lowest hit is applied last.
    always_comb begin
        any_hit  = 1'b0;
        win_flow = '0;
        for (int i = NUM_RULES - 1; i >= 0; i--) begin
            if (hits[i]) begin
                any_hit  = 1'b1;
                win_flow = flows[i];
            end
        end
    end

endmodule

// File: rtl/hdr_classifier.sv
module hdr_classifier
    import hfc_pkg::*;
#(
    parameter int NUM_RULES = 8,
    parameter int FLOW_W    = 4,
    localparam int IDX_W    = $clog2(NUM_RULES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hdr_valid,
    input  logic [31:0]       hdr_src_addr,
    input  logic [31:0]       hdr_dst_addr,
    input  logic [15:0]       hdr_src_port,
    input  logic [15:0]       hdr_dst_port,
    input  logic [7:0]        hdr_tos,
    input  logic [7:0]        hdr_proto,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_rule_on,
    input  logic [HDR_W-1:0]  wr_lo,
    input  logic [HDR_W-1:0]  wr_hi,
    input  logic [FLOW_W-1:0] wr_flow,
    output logic              res_valid,
    output logic              res_match,
    output logic [FLOW_W-1:0] res_flow
);

    hdr_t                             hdr;
    logic [NUM_RULES-1:0]             rule_on;
    hdr_t [NUM_RULES-1:0]             rule_lo;
    hdr_t [NUM_RULES-1:0]             rule_hi;
    logic [NUM_RULES-1:0][FLOW_W-1:0] rule_flow;
    logic [NUM_RULES-1:0]             hits;
    logic                             any_hit;
    logic [FLOW_W-1:0]                win_flow;

    always_comb begin
        hdr.src_addr = hdr_src_addr;
        hdr.dst_addr = hdr_dst_addr;
        hdr.src_port = hdr_src_port;
        hdr.dst_port = hdr_dst_port;
        hdr.tos      = hdr_tos;
        hdr.proto    = hdr_proto;
    end

    hfc_rule_table #(.NUM_RULES(NUM_RULES), .FLOW_W(FLOW_W)) u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_on    (wr_rule_on),
        .wr_lo    (hdr_t'(wr_lo)),
        .wr_hi    (hdr_t'(wr_hi)),
        .wr_flow  (wr_flow),
        .rule_on  (rule_on),
        .rule_lo  (rule_lo),
        .rule_hi  (rule_hi),
        .rule_flow(rule_flow)
    );

    for (genvar i = 0; i < NUM_RULES; i++) begin : g_cmp
        hfc_rule_match u_match (
            .hdr(hdr),
            .on (rule_on[i]),
            .lo (rule_lo[i]),
            .hi (rule_hi[i]),
            .hit(hits[i])
        );
    end

    hfc_prio_pick #(.NUM_RULES(NUM_RULES), .FLOW_W(FLOW_W)) u_pick (
        .hits    (hits),
        .flows   (rule_flow),
        .any_hit (any_hit),
        .win_flow(win_flow)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_match <= 1'b0;
            res_flow  <= '0;
        end else begin
            res_valid <= hdr_valid;
            res_match <= hdr_valid && any_hit;
            res_flow  <= (hdr_valid && any_hit) ? win_flow : '0;
        end
    end

endmodule

// File: rtl/hfc_checker.sv
module hfc_checker #(
    parameter int FLOW_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              hdr_valid,
    input logic              res_valid,
    input logic              res_match,
    input logic [FLOW_W-1:0] res_flow
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!res_valid && !res_match && res_flow == '0));

    // R2
    valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
        hdr_valid |=> res_valid);

    // R2
    idle_follows_chk: assert property (@(posedge clk) disable iff (rst)
        !hdr_valid |=> !res_valid);

    // R7
    miss_flow_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !res_match |-> (res_flow == '0));

    // R9
    match_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        res_match |-> res_valid);

endmodule

bind hdr_classifier hfc_checker #(.FLOW_W(FLOW_W)) u_hfc_checker (
    .clk      (clk),
    .rst      (rst),
    .hdr_valid(hdr_valid),
    .res_valid(res_valid),
    .res_match(res_match),
    .res_flow (res_flow)
);

// File: tb/test_hdr_classifier.sv
module test_hdr_classifier;
    import hfc_pkg::*;

    typedef struct packed {
        hdr_t       h;
        logic       m;
        logic [3:0] f;
    } vec_t;

    localparam int NV = 12;
    // Rules: 0 src 0A000000..0A0000FF proto 6 -> flow 5; 1 dport 80 -> flow 9;
    // 2 tos 20..3F -> flow 2; 3 disabled catch-all -> flow 7.
    localparam vec_t VECS [NV] = '{
        '{'{32'h0A000010, 32'h0, 16'h0, 16'd80,  8'h00, 8'd6 }, 1'b1, 4'd5}, // R5 rules 0,1 overlap
        '{'{32'h0A000010, 32'h0, 16'h0, 16'd80,  8'h00, 8'd17}, 1'b1, 4'd9},
        '{'{32'h0B000000, 32'h0, 16'h0, 16'd443, 8'h00, 8'd6 }, 1'b0, 4'd0}, // R6 R7
        '{'{32'h0A000000, 32'h1, 16'h5, 16'd443, 8'h00, 8'd6 }, 1'b1, 4'd5}, // R3 low bound
        '{'{32'h0A0000FF, 32'h2, 16'h6, 16'd443, 8'h00, 8'd6 }, 1'b1, 4'd5}, // R3 high bound
        '{'{32'h0A000100, 32'h0, 16'h0, 16'd81,  8'h00, 8'd6 }, 1'b0, 4'd0}, // R4 above
        '{'{32'h09FFFFFF, 32'h0, 16'h0, 16'd81,  8'h00, 8'd6 }, 1'b0, 4'd0}, // R4 below
        '{'{32'h00000000, 32'h0, 16'h0, 16'd443, 8'h20, 8'd1 }, 1'b1, 4'd2}, // R3
        '{'{32'h00000000, 32'h0, 16'h0, 16'd443, 8'h3F, 8'd1 }, 1'b1, 4'd2}, // R3
        '{'{32'h00000000, 32'h0, 16'h0, 16'd443, 8'h40, 8'd1 }, 1'b0, 4'd0}, // R4
        '{'{32'h00000000, 32'h0, 16'h0, 16'd443, 8'h1F, 8'd1 }, 1'b0, 4'd0}, // R4
        '{'{32'h0A000010, 32'h0, 16'h0, 16'd79,  8'h00, 8'd17}, 1'b0, 4'd0}  // R4
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              hdr_valid = 1'b0;
    hdr_t              hdr = '0;
    logic              wr_en = 1'b0;
    logic [2:0]        wr_idx = '0;
    logic              wr_rule_on = 1'b0;
    logic [HDR_W-1:0]  wr_lo = '0;
    logic [HDR_W-1:0]  wr_hi = '0;
    logic [3:0]        wr_flow = '0;
    logic              res_valid;
    logic              res_match;
    logic [3:0]        res_flow;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hdr_classifier i_hdr_classifier (
        .clk         (clk),
        .rst         (rst),
        .hdr_valid   (hdr_valid),
        .hdr_src_addr(hdr.src_addr),
        .hdr_dst_addr(hdr.dst_addr),
        .hdr_src_port(hdr.src_port),
        .hdr_dst_port(hdr.dst_port),
        .hdr_tos     (hdr.tos),
        .hdr_proto   (hdr.proto),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_rule_on  (wr_rule_on),
        .wr_lo       (wr_lo),
        .wr_hi       (wr_hi),
        .wr_flow     (wr_flow),
        .res_valid   (res_valid),
        .res_match   (res_match),
        .res_flow    (res_flow)
    );

    task automatic check(input string req, input logic ev, input logic em, input logic [3:0] ef);
        checks++;
        if (res_valid !== ev || res_match !== em || res_flow !== ef) begin
            failures++;
            $display("FAIL %s: valid/match/flow actual %b/%b/%0d expected %b/%b/%0d",
                     req, res_valid, res_match, res_flow, ev, em, ef);
        end
    endtask

    function automatic hdr_t full_lo();
        return '0;
    endfunction

    function automatic hdr_t full_hi();
        return '1;
    endfunction

    task automatic write_rule(input int idx, input logic on, input hdr_t lo, input hdr_t hi,
                              input logic [3:0] fl);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'(idx); wr_rule_on = on;
        wr_lo = lo; wr_hi = hi; wr_flow = fl;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Header applied at a falling edge, result sampled at the next falling edge.
    task automatic lookup(input hdr_t h);
        @(negedge clk);
        hdr = h; hdr_valid = 1'b1;
        @(negedge clk);
        hdr_valid = 1'b0;
    endtask

    initial begin
        #100000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        hdr_t lo, hi, h;
        repeat (3) @(negedge clk);
        check("R1 reset outputs", 1'b0, 1'b0, 4'd0);
        rst = 1'b0;
        lookup('0);
        check("R1 empty table misses", 1'b1, 1'b0, 4'd0);

        lo = full_lo(); hi = full_hi();
        lo.src_addr = 32'h0A000000; hi.src_addr = 32'h0A0000FF;
        lo.proto = 8'd6; hi.proto = 8'd6;
        write_rule(0, 1'b1, lo, hi, 4'd5);
        lo = full_lo(); hi = full_hi();
        lo.dst_port = 16'd80; hi.dst_port = 16'd80;
        write_rule(1, 1'b1, lo, hi, 4'd9);
        lo = full_lo(); hi = full_hi();
        lo.tos = 8'h20; hi.tos = 8'h3F;
        write_rule(2, 1'b1, lo, hi, 4'd2);
        write_rule(3, 1'b0, full_lo(), full_hi(), 4'd7); // R6

        for (int i = 0; i < NV; i++) begin
            lookup(VECS[i].h);
            check($sformatf("R3/R4/R5/R6/R7 vector %0d", i), 1'b1, VECS[i].m, VECS[i].f);
        end

        // R2: idle cycle gives no result
        @(negedge clk);
        check("R2/R9 idle", 1'b0, 1'b0, 4'd0);

        // R10: overwrite rule 0
        lo = full_lo(); hi = full_hi();
        lo.src_addr = 32'h0B000000; hi.src_addr = 32'h0B0000FF;
        write_rule(0, 1'b1, lo, hi, 4'd12);
        lookup(VECS[0].h);
        check("R10 old rule 0 gone", 1'b1, 1'b1, 4'd9);
        h = VECS[2].h; h.src_addr = 32'h0B000005;
        lookup(h);
        check("R10 new rule 0 hits", 1'b1, 1'b1, 4'd12);

        // R8: write and lookup on the same edge
        h = VECS[2].h; h.src_addr = 32'h0C000000;
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd3; wr_rule_on = 1'b1;
        wr_lo = full_lo(); wr_hi = full_hi(); wr_flow = 4'd7;
        hdr = h; hdr_valid = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; hdr_valid = 1'b0;
        check("R8 same-edge lookup sees old table", 1'b1, 1'b0, 4'd0);
        lookup(h);
        check("R8 next lookup sees new rule", 1'b1, 1'b1, 4'd7);

        // R9: valid low after a hit
        @(negedge clk);
        check("R9 no valid no match", 1'b0, 1'b0, 4'd0);

        // R1: reset clears the table again
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        lookup(h);
        check("R1 table cleared by reset", 1'b1, 1'b0, 4'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule